// File: doc/BRIEF.md
# Ordered Store Queue with Load Bypass

This block sits between one core and its memory. Stores from the core are not written straight away; they wait in a small circular queue. The oldest waiting store is offered to memory on every cycle, so memory sees the stores in the order the core issued them. A load first looks through the queue. If any waiting store has the same address, the load takes the value of the newest one and memory is never asked. Otherwise the load goes out on the memory read port, and the value that comes back is handed to the core.

A fence request waits until every queued store has reached memory. All core requests share one valid/ready port with a two-bit operation code. There is no per-core tag, because the queue serves a single core. Addresses are whole words; there are no partial-width writes.

Top module: `tso_store_queue`

## Requirements
- R1: After reset the queue is empty: `mem_wr_valid`, `mem_rd_valid` and `ld_rsp_valid` are low, and a store request (operation code 0) sees `req_ready` high.
- R2: A store (operation code 0) accepted at a clock edge is appended behind all queued stores. It causes no memory write request in the cycle in which it is accepted.
- R3: `mem_wr_valid` is high exactly while the queue holds a store, and it always presents the oldest store. That store is removed at an edge where `mem_wr_ready` is high. While `mem_wr_ready` is low, the offered address and data do not change. Memory therefore receives the stores in issue order.
- R4: While DEPTH stores are queued, a store request sees `req_ready` low. This does not depend on `mem_wr_ready`.
- R5: When a store is accepted at the same edge at which the oldest store drains, both take effect and the number of queued stores stays the same.
- R6: A fence (operation code 2) sees `req_ready` high only when the queue is empty.
- R7: A load (operation code 1) whose address matches one or more queued stores returns the data of the newest matching store. `ld_rsp_valid` is high in the cycle after the load is accepted, and `mem_rd_valid` stays low for that load.
- R8: A load that matches no queued store drives `mem_rd_valid` and `mem_rd_addr` in the same cycle it is presented, and it is accepted when `mem_rd_ready` is high. The core response is `mem_rd_rsp_data` and is valid in the cycle in which `mem_rd_rsp_valid` is high.
- R9: While a load sent to memory awaits its response, further loads see `req_ready` low.
- R10: A load is compared against the queue contents as they were at the start of the cycle. This includes a store that drains to memory at the same edge.
- R11: Operation code 3 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted this cycle |
| req_op | input | 2 | 0 store, 1 load, 2 fence, 3 reserved |
| req_addr | input | ADDR_W | Word address of store or load |
| req_data | input | DATA_W | Store data |
| mem_wr_valid | output | 1 | Oldest queued store offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered store |
| mem_wr_addr | output | ADDR_W | Address of the offered store |
| mem_wr_data | output | DATA_W | Data of the offered store |
| mem_rd_valid | output | 1 | Load sent to memory |
| mem_rd_ready | input | 1 | Memory takes the load |
| mem_rd_addr | output | ADDR_W | Load address to memory |
| mem_rd_rsp_valid | input | 1 | Memory returns load data |
| mem_rd_rsp_data | input | DATA_W | Returned load data |
| ld_rsp_valid | output | 1 | Load result to the core |
| ld_rsp_data | output | DATA_W | Load result data |

## Verification
Some results are combinational and are due in the same cycle as their stimulus: `req_ready`, the memory read request, and the head store on the write port. A load served from the queue answers exactly one cycle after acceptance. A load served by memory answers in the cycle the memory response arrives. The bench drives every input just after a falling edge and samples everything 5 ns before the next rising edge. A behavioural model holds an ordered list of pending stores and an array for memory, and works out each expected value for that same sample point. Model updates (drain, enqueue, pending response) are applied only after the comparisons of that cycle, so every comparison uses the state from before the edge.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
   typedef enum logic [1:0] {
      TSQ_STORE = 2'd0,
      TSQ_LOAD  = 2'd1,
      TSQ_FENCE = 2'd2,
      TSQ_RSVD  = 2'd3
   } tsq_op_e;
endpackage

// File: rtl/tsq_ring_ctrl.sv
module tsq_ring_ctrl #(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + PTR_W'(1);
         if (pop)  rd_q <= rd_q + PTR_W'(1);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign wr_ptr = wr_q;
   assign rd_ptr = rd_q;
   assign count  = cnt_q;
   assign full   = (cnt_q == CNT_W'(DEPTH));
   assign empty  = (cnt_q == '0);

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
   assert_paired_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> (count == $past(count)));
endmodule

// File: rtl/tsq_entry_bank.sv
module tsq_entry_bank #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              push,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic [ADDR_W-1:0] ent_addr [DEPTH],
   output logic [DATA_W-1:0] ent_data [DEPTH]
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [ADDR_W-1:0] a_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (push && (wr_ptr == PTR_W'(i))) begin
            a_q <= in_addr;
            d_q <= in_data;
         end
      end
      assign ent_addr[i] = a_q;
      assign ent_data[i] = d_q;
   end
endmodule

// File: rtl/tsq_fwd_search.sv
module tsq_fwd_search #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic [CNT_W-1:0]  count,
   input  logic [ADDR_W-1:0] ent_addr [DEPTH],
   input  logic [DATA_W-1:0] ent_data [DEPTH],
   input  logic [ADDR_W-1:0] look_addr,
   output logic              hit,
   output logic [DATA_W-1:0] hit_data
);
   logic [DEPTH-1:0]  match;
   logic [DATA_W-1:0] age_data [DEPTH];

   // Slot k in age order: k = 0 is the oldest entry.
   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      logic [PTR_W-1:0] slot;
      assign slot        = rd_ptr + PTR_W'(k);
      assign match[k]    = (CNT_W'(k) < count) && (ent_addr[slot] == look_addr);
      assign age_data[k] = ent_data[slot];
   end

   // The youngest match wins: later k overrides earlier k.
   always_comb begin
      hit      = 1'b0;
      hit_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (match[k]) begin
            hit      = 1'b1;
            hit_data = age_data[k];
         end
      end
   end
endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue
   import tsq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_rsp_valid,
   input  logic [DATA_W-1:0] mem_rd_rsp_data,
   output logic              ld_rsp_valid,
   output logic [DATA_W-1:0] ld_rsp_data
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tso_store_queue: DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("tso_store_queue: ADDR_W and DATA_W must be positive");
   end

   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;
   logic              full, empty;
   logic [ADDR_W-1:0] ent_addr [DEPTH];
   logic [DATA_W-1:0] ent_data [DEPTH];
   logic              fwd_hit;
   logic [DATA_W-1:0] fwd_data;

   logic              is_st, is_ld, is_fence;
   logic              push, pop, ld_fire, req_fire;
   logic              rd_wait_q, hit_rsp_q;
   logic [DATA_W-1:0] hit_data_q;

   always_comb begin
      is_st    = (req_op == TSQ_STORE);
      is_ld    = (req_op == TSQ_LOAD);
      is_fence = (req_op == TSQ_FENCE);
      unique case (req_op)
         TSQ_STORE: req_ready = !full;
         TSQ_LOAD:  req_ready = !rd_wait_q && (fwd_hit || mem_rd_ready);
         TSQ_FENCE: req_ready = empty;
         default:   req_ready = 1'b0;
      endcase
      req_fire     = req_valid && req_ready;
      push         = req_fire && is_st;
      ld_fire      = req_fire && is_ld;
      mem_rd_valid = req_valid && is_ld && !rd_wait_q && !fwd_hit;
      mem_rd_addr  = req_addr;
      mem_wr_valid = !empty;
      mem_wr_addr  = ent_addr[rd_ptr];
      mem_wr_data  = ent_data[rd_ptr];
      pop          = mem_wr_valid && mem_wr_ready;
   end

   tsq_ring_ctrl #(.DEPTH(DEPTH)) i_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .pop    (pop),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .count  (count),
      .full   (full),
      .empty  (empty)
   );

   tsq_entry_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
      .clk      (clk),
      .push     (push),
      .wr_ptr   (wr_ptr),
      .in_addr  (req_addr),
      .in_data  (req_data),
      .ent_addr (ent_addr),
      .ent_data (ent_data)
   );

   tsq_fwd_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_search (
      .rd_ptr    (rd_ptr),
      .count     (count),
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .look_addr (req_addr),
      .hit       (fwd_hit),
      .hit_data  (fwd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_wait_q  <= 1'b0;
         hit_rsp_q  <= 1'b0;
         hit_data_q <= '0;
      end else begin
         hit_rsp_q <= ld_fire && fwd_hit;
         if (ld_fire && fwd_hit) hit_data_q <= fwd_data;
         if (ld_fire && !fwd_hit)   rd_wait_q <= 1'b1;
         else if (mem_rd_rsp_valid) rd_wait_q <= 1'b0;
      end
   end

   assign ld_rsp_valid = hit_rsp_q || (rd_wait_q && mem_rd_rsp_valid);
   assign ld_rsp_data  = rd_wait_q ? mem_rd_rsp_data : hit_data_q;

   assert_fence_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && is_fence) |-> !mem_wr_valid);
   assert_hit_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && fwd_hit) |-> !mem_rd_valid);
   assert_hit_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && fwd_hit) |=> ld_rsp_valid);
   assert_drain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
   assert_store_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> mem_wr_valid);
   assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wait_q |-> !mem_rd_valid);
   assert_rsvd_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_op == TSQ_RSVD) |-> !req_ready);
endmodule

// File: tb/test_tso_store_queue.sv
module test_tso_store_queue;
   localparam int AW = 3;
   localparam int DW = 16;
   localparam int DEPTH = 8;
   localparam time PERIOD = 20ns;

   logic clk = 1'b0;
   always #(PERIOD / 2) clk = ~clk;

   logic          rst_n;
   logic          req_valid, req_ready;
   logic [1:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;
   logic          mem_wr_valid, mem_wr_ready;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;
   logic          mem_rd_valid, mem_rd_ready;
   logic [AW-1:0] mem_rd_addr;
   logic          mem_rd_rsp_valid;
   logic [DW-1:0] mem_rd_rsp_data;
   logic          ld_rsp_valid;
   logic [DW-1:0] ld_rsp_data;

   tso_store_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_tso_store_queue (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr),
      .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_rsp_data(mem_rd_rsp_data),
      .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data)
   );

   int checks = 0;
   int fails = 0;
   bit done = 0;

   // Reference model: program-order pending stores plus a memory array.
   logic [DW-1:0] mem [1 << AW];
   logic [AW-1:0] q_a [$];
   logic [DW-1:0] q_d [$];
   bit            ld_wait = 0, hit_due = 0, accepted = 0, rand_ready = 0;
   logic [DW-1:0] hit_val, ld_exp, last_ld, rsp_val;
   int            rsp_cnt = -1;

   // Planned input values, applied at the next falling edge.
   logic          p_valid = 0, p_wrr = 0, p_rdr = 0;
   logic [1:0]    p_op = 0;
   logic [AW-1:0] p_addr = 0;
   logic [DW-1:0] p_data = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit model_hit(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bit h = 0;
      d = '0;
      foreach (q_a[i]) if (q_a[i] == a) begin h = 1; d = q_d[i]; end
      return h;
   endfunction

   task automatic evaluate();
      bit mh, exp_rdv, er, exp_lv;
      logic [DW-1:0] md, exp_ld;
      string tag;
      accepted = 0;
      chk(mem_wr_valid == (q_a.size() != 0), "R3 write valid", mem_wr_valid, q_a.size() != 0);
      if (q_a.size() != 0) begin
         chk(mem_wr_addr == q_a[0], "R3 head address", mem_wr_addr, q_a[0]);
         chk(mem_wr_data == q_d[0], "R3 head data", mem_wr_data, q_d[0]);
      end
      mh = model_hit(req_addr, md);
      exp_rdv = req_valid && req_op == 2'd1 && !ld_wait && !mh;
      chk(mem_rd_valid == exp_rdv, "R8 read request", mem_rd_valid, exp_rdv);
      if (exp_rdv) chk(mem_rd_addr == req_addr, "R8 read address", mem_rd_addr, req_addr);
      if (req_valid) begin
         case (req_op)
            2'd0:    begin er = q_a.size() < DEPTH; tag = "R4 store ready"; end
            2'd1:    begin er = !ld_wait && (mh || mem_rd_ready); tag = "R9 load ready"; end
            2'd2:    begin er = q_a.size() == 0; tag = "R6 fence ready"; end
            default: begin er = 0; tag = "R11 reserved ready"; end
         endcase
         chk(req_ready == er, tag, req_ready, er);
      end
      exp_lv = hit_due || (ld_wait && mem_rd_rsp_valid);
      exp_ld = hit_due ? hit_val : ld_exp;
      chk(ld_rsp_valid == exp_lv, "R7 R8 response valid", ld_rsp_valid, exp_lv);
      if (exp_lv) begin
         chk(ld_rsp_data == exp_ld, "R7 R8 response data", ld_rsp_data, exp_ld);
         last_ld = ld_rsp_data;
      end
      hit_due = 0;
      if (ld_wait && mem_rd_rsp_valid) ld_wait = 0;
      if (req_valid && req_ready) begin
         accepted = 1;
         if (req_op == 2'd1) begin
            if (mh) begin hit_due = 1; hit_val = md; end
            else begin
               ld_wait = 1; ld_exp = mem[req_addr]; rsp_val = mem[req_addr]; rsp_cnt = 1;
            end
         end
         if (req_op == 2'd0 && q_a.size() == 0)
            chk(!mem_wr_valid, "R2 no write at accept", mem_wr_valid, 0);
      end
      if (mem_wr_valid && mem_wr_ready && q_a.size() != 0) begin
         mem[q_a[0]] = q_d[0];
         void'(q_a.pop_front());
         void'(q_d.pop_front());
      end
      if (req_valid && req_ready && req_op == 2'd0) begin
         q_a.push_back(req_addr);
         q_d.push_back(req_data);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (rand_ready) begin
         p_wrr = ($urandom % 4) != 0;
         p_rdr = ($urandom % 3) != 0;
      end
      req_valid = p_valid; req_op = p_op; req_addr = p_addr; req_data = p_data;
      mem_wr_ready = p_wrr; mem_rd_ready = p_rdr;
      if (rsp_cnt == 0) begin
         mem_rd_rsp_valid = 1; mem_rd_rsp_data = rsp_val; rsp_cnt = -1;
      end else begin
         mem_rd_rsp_valid = 0; mem_rd_rsp_data = DW'($urandom);
         if (rsp_cnt > 0) rsp_cnt--;
      end
      #5ns;
      evaluate();
   endtask

   task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      p_valid = 1; p_op = op; p_addr = a; p_data = d;
      do tick(); while (!accepted);
      p_valid = 0;
   endtask

   task automatic hold(input logic [1:0] op, input logic [AW-1:0] a, input int n, input string tag);
      p_valid = 1; p_op = op; p_addr = a;
      for (int i = 0; i < n; i++) begin
         tick();
         chk(!accepted, tag, accepted, 0);
      end
      p_valid = 0;
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(16'h1000 + i);
      rst_n = 0;
      req_valid = 0; req_op = 0; req_addr = 0; req_data = 0;
      mem_wr_ready = 0; mem_rd_ready = 0; mem_rd_rsp_valid = 0; mem_rd_rsp_data = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #5ns;
      chk(!mem_wr_valid, "R1 write idle", mem_wr_valid, 0);
      chk(!mem_rd_valid, "R1 read idle", mem_rd_valid, 0);
      chk(!ld_rsp_valid, "R1 response idle", ld_rsp_valid, 0);
      chk(req_ready, "R1 store ready", req_ready, 1);

      // Fill with memory stalled; same address twice for the youngest-match case.
      issue(0, 2, 16'h0011); issue(0, 3, 16'h0022); issue(0, 2, 16'h0033);
      issue(0, 4, 16'h0044); issue(0, 5, 16'h0055); issue(0, 6, 16'h0066);
      issue(0, 7, 16'h0077); issue(0, 0, 16'h0088);
      hold(0, 1, 3, "R4 full blocks store");
      issue(1, 2, 0); tick();
      chk(last_ld == 16'h0033, "R7 youngest match", last_ld, 16'h0033);
      hold(2, 0, 3, "R6 fence waits");
      p_wrr = 1;
      issue(2, 0, 0);
      chk(q_a.size() == 0, "R6 fence after drain", q_a.size(), 0);

      // Miss goes to memory; a second load waits for the first.
      p_rdr = 1;
      issue(1, 2, 0); tick(); tick();
      chk(last_ld == 16'h0033, "R8 miss data", last_ld, 16'h0033);
      issue(1, 3, 0);
      hold(1, 4, 1, "R9 second load waits");
      issue(1, 4, 0); tick(); tick(); tick();

      // Paired drain and enqueue keep the count.
      p_wrr = 0;
      for (int i = 0; i < DEPTH - 1; i++) issue(0, AW'(i), DW'(16'h0200 + i));
      p_wrr = 1;
      issue(0, 1, 16'h0300);
      p_wrr = 0;
      issue(0, 2, 16'h0301);
      hold(0, 3, 2, "R5 full after paired cycle");
      p_wrr = 1;
      issue(2, 0, 0);

      // Load hits the entry that drains at the same edge.
      p_wrr = 0;
      issue(0, 5, 16'h5A5A);
      p_wrr = 1;
      issue(1, 5, 0); tick();
      chk(last_ld == 16'h5A5A, "R10 load sees draining entry", last_ld, 16'h5A5A);
      hold(3, 0, 3, "R11 reserved op ignored");
      chk(!ld_rsp_valid && !mem_rd_valid, "R11 no side effect", ld_rsp_valid, 0);

      // Mixed traffic with random memory readiness.
      rand_ready = 1;
      for (int n = 0; n < 1500; n++) begin
         int r = $urandom % 10;
         logic [1:0] op = (r < 5) ? 2'd0 : (r < 9) ? 2'd1 : 2'd2;
         issue(op, AW'($urandom), DW'($urandom));
      end
      repeat (20) tick();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule